// File: doc/BRIEF.md
# SRAM Bank Timing Sequencer

This block runs the strobe timing for one external static-memory, ROM or I/O bank. A core-side request carries a start pulse, a start address, a read/write flag, a burst length and write data. While idle, the block takes the request and steps through one or more beats. In each beat it places chip select, output enable and write enable at programmed offsets. It drives byte enables that suit the configured bus width and raises a last-beat flag in the final beat. Between beats the address advances by the bus width in bytes. After the last beat an optional hold phase keeps every output frozen. A one-cycle done pulse then ends the access.

The first beat and the later burst beats each have their own programmed length. A configuration word supplies every timing value. The block checks that word all the time and reports a setting whose wait count is too short to fit the strobe offsets. While that report is up, the block does not begin an access.

Top module: `sram_bank_seq`

## Requirements
- R14: The 18-bit configuration word is laid out as: [3:0] wait count W, [5:4] burst wait count B, [8:6] hold count H, [10:9] width code, [11] burst enable, [12] CS delay, [13] OE delay, [14] WE delay, [15] WE early-off, [16] and [17] reserved flags that have no effect on any output.
- R1: The first beat of an access lasts W+1 clock cycles. It begins in the cycle after the clock edge that accepts the start.
- R2: When burst enable is 1, an access has burst-length+1 beats (burst length 0..3), and each beat after the first lasts B+1 cycles. When burst enable is 0, the access has exactly one beat whatever the burst length.
- R3: Within every beat, counting from cycle 0, chip select is high from cycle CS delay to the end of the beat and low before that.
- R4: In a read, output enable is high from beat cycle CS delay + OE delay and write enable stays low. In a write, write enable is high from beat cycle CS delay + WE delay and output enable stays low.
- R5: When WE early-off is 1, write enable is low in the last cycle of each beat.
- R6: When H ≥ 2, H−1 hold cycles follow the last beat. In these cycles every strobe, address, byte-enable, last-beat and data-drive output keeps its value from the last beat cycle. When H is 0 or 1 there is no hold phase.
- R7: The last-beat flag is high in every cycle of the final beat and in the hold phase, and low at all other times.
- R8: The address output equals the start address in the first beat and grows by the width step in each later beat. The width step is 1 for width code 0, 2 for code 1, and 4 for codes 2 and 3.
- R9: During an access the byte enables are 4'b1111 for word width. For halfword width they are {A1, A0, 1, 1}, and for byte width {A1, A0, 0, 1}, where A1:A0 are the two lowest current address bits. When idle they are 0.
- R10: One cycle after the last beat or hold cycle, done is high for exactly one cycle with all strobes low. The block accepts a start only when idle, so a start during an access changes nothing.
- R11: The error output is high exactly when W < CS delay + WE delay + WE early-off or W < CS delay + OE delay + WE early-off. A start is ignored while the error output is high.
- R12: During a write access, including hold, the data-drive output is high and the data output carries the write data captured at start. During a read or when idle, data-drive is low.
- R13: After reset all strobes, last-beat, byte enables, data-drive and done are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_i | input | 18 | Bank timing configuration word |
| start_i | input | 1 | Access request, sampled when idle |
| addr_i | input | ADDR_W | Start byte address |
| rd_i | input | 1 | 1 = read, 0 = write |
| blen_i | input | BLEN_W | Burst beats minus one |
| wdata_i | input | DATA_W | Write data |
| addr_o | output | ADDR_W | Current bus address |
| cs_o | output | 1 | Chip select (active high) |
| oe_o | output | 1 | Output enable (active high) |
| we_o | output | 1 | Write enable (active high) |
| be_o | output | DATA_W/8 | Byte enables / low address bits |
| last_o | output | 1 | Final-beat flag |
| wdata_o | output | DATA_W | Captured write data |
| data_oe_o | output | 1 | Data drive enable |
| done_o | output | 1 | Access-complete pulse |
| cfg_err_o | output | 1 | Illegal timing configuration |

## Verification
Directed accesses cover a single-beat word write with early-off, a four-beat halfword read with a hold phase, and a three-beat byte write from an odd address, where the enable lanes show the low address bits rolling over. A long first beat paired with one-cycle later beats tells the first-beat length apart from the later-beat length. An access with burst enable cleared but a burst length of 3 and the reserved flags set shows that those inputs do not lengthen or alter the access. A start pulsed mid-access, and a start under an illegal wait setting, show that requests outside the idle, legal state change nothing on the ports.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

  localparam int WAIT_W  = 4;
  localparam int BWAIT_W = 2;
  localparam int HOLD_W  = 3;
  localparam int WID_W   = 2;
  localparam int LEN_W   = WAIT_W + 1;

  typedef struct packed {
    logic               rsv_b;
    logic               rsv_a;
    logic               we_eoff;
    logic               we_dly;
    logic               oe_dly;
    logic               cs_dly;
    logic               burst_en;
    logic [WID_W-1:0]   width;
    logic [HOLD_W-1:0]  hold;
    logic [BWAIT_W-1:0] bwait;
    logic [WAIT_W-1:0]  wait_st;
  } bank_cfg_t;

  localparam int CFG_W = $bits(bank_cfg_t);

  typedef enum logic [1:0] {PH_IDLE, PH_BEAT, PH_HOLD, PH_DONE} phase_t;

  function automatic logic [LEN_W-1:0] first_len(bank_cfg_t c);
    return LEN_W'(c.wait_st) + LEN_W'(1);
  endfunction

  function automatic logic [LEN_W-1:0] next_len(bank_cfg_t c);
    return LEN_W'(c.bwait) + LEN_W'(1);
  endfunction

  function automatic logic [2:0] width_step(logic [WID_W-1:0] w);
    case (w)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic cfg_legal(bank_cfg_t c);
    logic [WAIT_W-1:0] we_need, oe_need;
    we_need = WAIT_W'(c.cs_dly) + WAIT_W'(c.we_dly) + WAIT_W'(c.we_eoff);
    oe_need = WAIT_W'(c.cs_dly) + WAIT_W'(c.oe_dly) + WAIT_W'(c.we_eoff);
    return (c.wait_st >= we_need) && (c.wait_st >= oe_need);
  endfunction

  function automatic logic [3:0] lane_enables(logic [WID_W-1:0] w, logic [1:0] alo);
    case (w)
      2'd0:    return {alo[1], alo[0], 2'b01};
      2'd1:    return {alo[1], alo[0], 2'b11};
      default: return 4'b1111;
    endcase
  endfunction

endpackage

// File: rtl/sram_cfg_check.sv
module sram_cfg_check
  import sram_seq_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  bank_cfg_t          cfg_live_i,
  input  bank_cfg_t          cfg_run_i,
  output logic               legal_o,
  output logic [LEN_W-1:0]   first_len_o,
  output logic [LEN_W-1:0]   next_len_o,
  output logic [ADDR_W-1:0]  step_o
);
  assign legal_o     = cfg_legal(cfg_live_i);
  assign first_len_o = first_len(cfg_run_i);
  assign next_len_o  = next_len(cfg_run_i);
  assign step_o      = ADDR_W'(width_step(cfg_run_i.width));
endmodule

// File: rtl/sram_addr_step.sv
module sram_addr_step #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              adv_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] step_i,
  output logic [ADDR_W-1:0] addr_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      addr_o <= '0;
    else if (load_i) addr_o <= addr_i;
    else if (adv_i)  addr_o <= addr_o + step_i;
  end
endmodule

// File: rtl/sram_strobe_gen.sv
module sram_strobe_gen #(
  parameter int T_W = 5
) (
  input  logic           active_i,
  input  logic           rd_i,
  input  logic [T_W-1:0] t_i,
  input  logic [T_W-1:0] len_i,
  input  logic           cs_dly_i,
  input  logic           oe_dly_i,
  input  logic           we_dly_i,
  input  logic           eoff_i,
  output logic           cs_o,
  output logic           oe_o,
  output logic           we_o
);
  logic [T_W-1:0] oe_at, we_at;
  logic           tail;

  assign oe_at = T_W'(cs_dly_i) + T_W'(oe_dly_i);
  assign we_at = T_W'(cs_dly_i) + T_W'(we_dly_i);
  assign tail  = eoff_i && (t_i == len_i - T_W'(1));

  assign cs_o = active_i && (t_i >= T_W'(cs_dly_i));
  assign oe_o = active_i && rd_i && (t_i >= oe_at);
  assign we_o = active_i && !rd_i && (t_i >= we_at) && !tail;
endmodule

// File: rtl/sram_bank_seq.sv
module sram_bank_seq
  import sram_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int BLEN_W = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CFG_W-1:0]    cfg_i,
  input  logic                start_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                rd_i,
  input  logic [BLEN_W-1:0]   blen_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [ADDR_W-1:0]   addr_o,
  output logic                cs_o,
  output logic                oe_o,
  output logic                we_o,
  output logic [DATA_W/8-1:0] be_o,
  output logic                last_o,
  output logic [DATA_W-1:0]   wdata_o,
  output logic                data_oe_o,
  output logic                done_o,
  output logic                cfg_err_o
);
  localparam int BE_W = DATA_W / 8;

  bank_cfg_t          cfg_live, cfg_q;
  phase_t             phase_q;
  logic [LEN_W-1:0]   t_q;
  logic [BLEN_W-1:0]  beat_q, nb_q;
  logic [HOLD_W-1:0]  hcnt_q;
  logic               rd_q;
  logic [DATA_W-1:0]  data_q;

  logic               legal_w;
  logic [LEN_W-1:0]   len_first_w, len_next_w, len_w;
  logic [ADDR_W-1:0]  step_w;

  // named events for the checker
  logic idle_w, active_w, hold_w, accept_w;
  logic beat_end_w, last_beat_w, beat_adv_w;

  assign cfg_live = bank_cfg_t'(cfg_i);

  sram_cfg_check #(.ADDR_W(ADDR_W)) u_cfg (
    .cfg_live_i  (cfg_live),
    .cfg_run_i   (cfg_q),
    .legal_o     (legal_w),
    .first_len_o (len_first_w),
    .next_len_o  (len_next_w),
    .step_o      (step_w)
  );

  assign len_w       = (beat_q == '0) ? len_first_w : len_next_w;
  assign idle_w      = (phase_q == PH_IDLE);
  assign hold_w      = (phase_q == PH_HOLD);
  assign active_w    = (phase_q == PH_BEAT) || hold_w;
  assign accept_w    = idle_w && start_i && legal_w;
  assign beat_end_w  = (phase_q == PH_BEAT) && (t_q == len_w - LEN_W'(1));
  assign last_beat_w = (beat_q == nb_q);
  assign beat_adv_w  = beat_end_w && !last_beat_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      t_q     <= '0;
      beat_q  <= '0;
      nb_q    <= '0;
      hcnt_q  <= '0;
      rd_q    <= 1'b0;
      data_q  <= '0;
      cfg_q   <= '0;
    end else begin
      case (phase_q)
        PH_IDLE: if (accept_w) begin
          phase_q <= PH_BEAT;
          t_q     <= '0;
          beat_q  <= '0;
          nb_q    <= cfg_live.burst_en ? blen_i : '0;
          rd_q    <= rd_i;
          data_q  <= wdata_i;
          cfg_q   <= cfg_live;
        end
        PH_BEAT: begin
          if (beat_adv_w) begin
            beat_q <= beat_q + BLEN_W'(1);
            t_q    <= '0;
          end else if (beat_end_w) begin
            if (cfg_q.hold >= HOLD_W'(2)) begin
              phase_q <= PH_HOLD;
              hcnt_q  <= cfg_q.hold - HOLD_W'(2);
            end else begin
              phase_q <= PH_DONE;
            end
          end else begin
            t_q <= t_q + LEN_W'(1);
          end
        end
        PH_HOLD: begin
          if (hcnt_q == '0) phase_q <= PH_DONE;
          else              hcnt_q  <= hcnt_q - HOLD_W'(1);
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  sram_addr_step #(.ADDR_W(ADDR_W)) u_addr (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (accept_w),
    .adv_i  (beat_adv_w),
    .addr_i (addr_i),
    .step_i (step_w),
    .addr_o (addr_o)
  );

  sram_strobe_gen #(.T_W(LEN_W)) u_strb (
    .active_i (active_w),
    .rd_i     (rd_q),
    .t_i      (t_q),
    .len_i    (len_w),
    .cs_dly_i (cfg_q.cs_dly),
    .oe_dly_i (cfg_q.oe_dly),
    .we_dly_i (cfg_q.we_dly),
    .eoff_i   (cfg_q.we_eoff),
    .cs_o     (cs_o),
    .oe_o     (oe_o),
    .we_o     (we_o)
  );

  assign be_o      = active_w ? BE_W'(lane_enables(cfg_q.width, addr_o[1:0])) : '0;
  assign last_o    = active_w && last_beat_w;
  assign wdata_o   = data_q;
  assign data_oe_o = active_w && !rd_q;
  assign done_o    = (phase_q == PH_DONE);
  assign cfg_err_o = !legal_w;
endmodule

// File: rtl/sram_bank_seq_chk.sv
module sram_bank_seq_chk #(
  parameter int ADDR_W = 32,
  parameter int BE_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              cs_o,
  input logic              oe_o,
  input logic              we_o,
  input logic              last_o,
  input logic              done_o,
  input logic              cfg_err_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic [BE_W-1:0]   be_o,
  input logic              idle_w,
  input logic              active_w,
  input logic              hold_w,
  input logic              beat_end_w,
  input logic              beat_adv_w,
  input logic              eoff_w,
  input logic [ADDR_W-1:0] step_w
);
  a_r4_strobe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(oe_o && we_o));

  a_r3_strobe_under_cs: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_o || we_o) |-> cs_o);

  a_r5_we_early_off: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_end_w && eoff_w) |-> !we_o);

  a_r6_hold_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    hold_w |-> ($stable(cs_o) && $stable(oe_o) && $stable(we_o) &&
                $stable(addr_o) && $stable(be_o) && $stable(last_o)));

  a_r7_last_in_access: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> active_w);

  a_r8_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    beat_adv_w |=> (addr_o == $past(addr_o + step_w)));

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r10_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !(cs_o || oe_o || we_o || last_o));

  a_r11_err_blocks_start: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_err_o && idle_w && start_i) |=> !active_w);
endmodule

bind sram_bank_seq sram_bank_seq_chk #(.ADDR_W(ADDR_W), .BE_W(BE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .cs_o       (cs_o),
  .oe_o       (oe_o),
  .we_o       (we_o),
  .last_o     (last_o),
  .done_o     (done_o),
  .cfg_err_o  (cfg_err_o),
  .addr_o     (addr_o),
  .be_o       (be_o),
  .idle_w     (idle_w),
  .active_w   (active_w),
  .hold_w     (hold_w),
  .beat_end_w (beat_end_w),
  .beat_adv_w (beat_adv_w),
  .eoff_w     (cfg_q.we_eoff),
  .step_w     (step_w)
);

// File: tb/sim_sram_bank_seq.sv
module sim_sram_bank_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [17:0] cfg_i = '0;
  logic        start_i = 1'b0;
  logic [31:0] addr_i = '0;
  logic        rd_i = 1'b0;
  logic [1:0]  blen_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] addr_o, wdata_o;
  logic        cs_o, oe_o, we_o, last_o, data_oe_o, done_o, cfg_err_o;
  logic [3:0]  be_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  sram_bank_seq u0 (
    .clk(clk), .rst_n(rst_n), .cfg_i(cfg_i), .start_i(start_i), .addr_i(addr_i),
    .rd_i(rd_i), .blen_i(blen_i), .wdata_i(wdata_i), .addr_o(addr_o), .cs_o(cs_o),
    .oe_o(oe_o), .we_o(we_o), .be_o(be_o), .last_o(last_o), .wdata_o(wdata_o),
    .data_oe_o(data_oe_o), .done_o(done_o), .cfg_err_o(cfg_err_o)
  );

  task automatic chk(input string tag, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // R14 field view of a configuration word
  function automatic logic [17:0] mk_cfg(int w, int bw, int h, int wid, bit ben, bit csd,
                                         bit oed, bit wed, bit eoff, bit ra, bit rb);
    logic [17:0] c;
    c = '0;
    c[3:0] = 4'(w);   c[5:4] = 2'(bw);  c[8:6] = 3'(h);  c[10:9] = 2'(wid);
    c[11] = ben; c[12] = csd; c[13] = oed; c[14] = wed; c[15] = eoff;
    c[16] = ra; c[17] = rb;
    return c;
  endfunction

  task automatic expect_cycle(input logic [17:0] c, input bit rd, input int b, input int nb,
                              input int t, input int len, input logic [31:0] a,
                              input logic [31:0] wd, input bit in_hold);
    int wid, csd, oen, wen;
    bit eoff, tail;
    logic [3:0] be;
    string tg;
    wid = int'(c[10:9]); csd = int'(c[12]);
    oen = csd + int'(c[13]); wen = csd + int'(c[14]); eoff = c[15];
    tail = eoff && (t == len - 1);
    if (wid == 0)      be = {a[1], a[0], 2'b01};
    else if (wid == 1) be = {a[1], a[0], 2'b11};
    else               be = 4'b1111;
    tg = in_hold ? "R6" : ((b == 0) ? "R1" : "R2");
    chk({tg, "/R3"}, "cs", cs_o, t >= csd);
    chk({tg, "/R4"}, "oe", oe_o, rd && t >= oen);
    chk(tail ? {tg, "/R5"} : {tg, "/R4"}, "we", we_o, !rd && t >= wen && !tail);
    chk({tg, "/R7"}, "last", last_o, b == nb - 1);
    chk({tg, "/R8"}, "addr", addr_o, a);
    chk({tg, "/R9"}, "be", be_o, be);
    chk({tg, "/R12"}, "data_oe", data_oe_o, !rd);
    if (!rd) chk({tg, "/R12"}, "wdata", wdata_o, wd);
    chk({tg, "/R10"}, "done", done_o, 1'b0);
  endtask

  // poke >= 0: cycle index at which a second start is pulsed (R10)
  task automatic do_access(input string nm, input logic [17:0] c, input logic [31:0] a0,
                           input bit rd, input logic [1:0] bl, input logic [31:0] wd,
                           input int poke);
    int nb, step, len, cyc, hold;
    logic [31:0] a;
    cfg_i = c; addr_i = a0; rd_i = rd; blen_i = bl; wdata_i = wd; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    nb   = c[11] ? int'(bl) + 1 : 1;
    step = (c[10:9] == 2'd0) ? 1 : (c[10:9] == 2'd1) ? 2 : 4;
    hold = int'(c[8:6]);
    cyc = 0;
    len = 1;
    a = a0;
    for (int b = 0; b < nb; b++) begin
      len = (b == 0) ? int'(c[3:0]) + 1 : int'(c[5:4]) + 1;
      a = a0 + 32'(b * step);
      for (int t = 0; t < len; t++) begin
        expect_cycle(c, rd, b, nb, t, len, a, wd, 1'b0);
        if (cyc == poke) begin start_i = 1'b1; addr_i = ~a0; rd_i = ~rd; end
        else start_i = 1'b0;
        cyc++;
        @(negedge clk);
      end
    end
    start_i = 1'b0;
    if (hold >= 2)
      for (int h = 1; h < hold; h++) begin
        expect_cycle(c, rd, nb - 1, nb, len - 1, len, a, wd, 1'b1);
        @(negedge clk);
      end
    chk("R10", {nm, " done"}, done_o, 1'b1);
    chk("R10", {nm, " done cs"}, cs_o, 1'b0);
    chk("R10", {nm, " done be"}, be_o, 4'b0);
    @(negedge clk);
    chk("R10", {nm, " done width"}, done_o, 1'b0);
    chk("R10", {nm, " idle cs"}, cs_o, 1'b0);
    chk("R12", {nm, " idle data_oe"}, data_oe_o, 1'b0);
  endtask

  task automatic t_reset;
    chk("R13", "cs", cs_o, 1'b0);   chk("R13", "oe", oe_o, 1'b0);
    chk("R13", "we", we_o, 1'b0);   chk("R13", "last", last_o, 1'b0);
    chk("R13", "done", done_o, 1'b0); chk("R13", "be", be_o, 4'b0);
    chk("R13", "data_oe", data_oe_o, 1'b0);
  endtask

  task automatic t_cfg_error;
    // W=1 with CS delay and WE delay: needs 2 -> illegal (R11)
    cfg_i = mk_cfg(1, 0, 0, 2, 0, 1, 0, 1, 0, 0, 0);
    #1 chk("R11", "err illegal we", cfg_err_o, 1'b1);
    cfg_i = mk_cfg(2, 0, 0, 2, 0, 1, 1, 0, 1, 0, 0);
    #1 chk("R11", "err illegal oe", cfg_err_o, 1'b1);
    cfg_i = mk_cfg(3, 0, 0, 2, 0, 1, 1, 1, 1, 0, 0);
    #1 chk("R11", "err legal edge", cfg_err_o, 1'b0);
    cfg_i = mk_cfg(1, 0, 0, 2, 0, 1, 0, 1, 0, 0, 0);
    addr_i = 32'h40; rd_i = 1'b0; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int i = 0; i < 5; i++) begin
      chk("R11", "cs after rejected start", cs_o, 1'b0);
      chk("R11", "done after rejected start", done_o, 1'b0);
      @(negedge clk);
    end
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cfg_error();
    // word single write, early-off
    do_access("word_wr", mk_cfg(3, 0, 0, 2, 0, 1, 0, 1, 1, 0, 0), 32'h100, 0, 2'd0,
              32'hDEAD_BEEF, -1);
    // halfword 4-beat read with hold phase
    do_access("half_rd", mk_cfg(4, 2, 3, 1, 1, 1, 1, 0, 0, 0, 0), 32'h1002, 1, 2'd3,
              32'h0, -1);
    // byte 3-beat write from odd address, early-off
    do_access("byte_wr", mk_cfg(2, 1, 0, 0, 1, 0, 0, 1, 1, 0, 0), 32'h2003, 0, 2'd2,
              32'h1234_5678, -1);
    // burst disabled, reserved flags set, H=1 (R14, R2)
    do_access("R14_single", mk_cfg(5, 3, 1, 3, 0, 0, 1, 1, 0, 1, 1), 32'h300, 1, 2'd3,
              32'h0, -1);
    // second start during access ignored (R10)
    do_access("busy_start", mk_cfg(3, 1, 2, 2, 1, 1, 1, 0, 0, 0, 0), 32'h500, 1, 2'd1,
              32'h0, 2);
    // long first beat, one-cycle later beats, long hold
    do_access("long_first", mk_cfg(15, 0, 7, 2, 1, 1, 0, 0, 0, 0, 0), 32'hFFFF_FFFC, 0,
              2'd1, 32'hA5A5_5A5A, -1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule